// File: doc/BRIEF.md
# Capture Timer with Reload Timer

This block is a timer unit built from two down-counters. Counter I is a reload timer: on each underflow it reloads from a software-set reload value and can toggle a waveform output. Counter II runs continuously, stepping down on every tick. A qualifying edge on the external capture pin copies Counter II into a capture register. Optionally, the same edge then presets Counter II to all ones, so that successive captured values give the period between edges directly.

There are four interrupt sources, A to D. Each has an enable bit and a sticky pending flag. Sources A, B and C are merged onto the first interrupt line, and source D alone drives the second. Source A is the Counter I underflow, B is a capture event and D is the Counter II underflow. Source C has no event in this mode and never becomes pending. Software reaches everything through a simple register port: writes are synchronous and reads are combinational.

The capture pin passes through a two-flop synchronizer and then a qualifier state machine. The machine has three states. In WAIT it needs the pin at its inactive level and moves to ARMED when it sees that level. In ARMED, the active level moves it to FIRE. FIRE lasts one cycle and raises the capture event, then goes back to WAIT if the pin is still active, or to ARMED if it is not. Any change of the polarity setting forces the machine back to WAIT.

Top module: `dual_timer_capture`

## Requirements
- R1: Counter II (address 4) decreases by one on each cycle with `tick` high and holds its value while `tick` is low.
- R2: A tick taken while Counter II is 0 wraps it to 16'hFFFF and sets pending flag D (pending register bit 3).
- R3: A qualifying edge on `cap_pin`, including a pulse one clock long, copies Counter II into the capture register (address 5) and sets pending flag B (bit 1), within six clock cycles of the edge.
- R4: Control bit 2 selects the capture polarity: 0 responds to rising edges and 1 to falling edges. Edges of the other polarity capture nothing and set no flag.
- R5: With control bit 3 set, a capture first latches the count and then loads Counter II with 16'hFFFF. With the bit clear, Counter II is left unchanged by a capture.
- R6: While control bit 0 is set, Counter I (address 3) decreases on each tick. A tick taken at 0 instead loads the reload value (address 2) and sets pending flag A (bit 0). While the bit is clear, Counter I holds.
- R7: With control bit 1 set, `wave_o` toggles on every Counter I underflow. With the bit clear, it holds.
- R8: The pending flags (address 1) are write-one-to-clear: writing a 1 clears that flag, and flags written with 0 are untouched.
- R9: `irq1_o` is high when any of flags A, B or C is pending with its enable set (control bits 4, 5, 6). `irq2_o` is high when flag D is pending with control bit 7 set.
- R10: After reset, control, pending, reload, Counter I and capture read 0, Counter II reads 16'hFFFF, and both interrupt lines and `wave_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable for both counters |
| cap_pin | input | 1 | External capture input (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 pending, 2 reload, 3 Counter I, 4 Counter II, 5 capture |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| wave_o | output | 1 | Waveform output toggled on Counter I underflow |
| irq1_o | output | 1 | Interrupt line for sources A, B, C |
| irq2_o | output | 1 | Interrupt line for source D |

## Verification
The hardest case to reach from the ports is a capture whose value can be predicted exactly. The pin goes through a synchronizer and the qualifier machine before the count is sampled, so a free-running count would be captured a few cycles late. The bench therefore writes a known value into Counter II and holds `tick` low while it toggles the pin, which makes the captured value equal to that written value. A Counter II underflow would normally take 65536 ticks. The bench reaches it by writing a small count and ticking past zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CAP_WAIT  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_FIRE  = 2'd2
    } cap_state_e;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_PEND = 3'd1;
    localparam logic [2:0] ADDR_RLD  = 3'd2;
    localparam logic [2:0] ADDR_CNT1 = 3'd3;
    localparam logic [2:0] ADDR_CNT2 = 3'd4;
    localparam logic [2:0] ADDR_CAPT = 3'd5;

    localparam int CTL_RUN1   = 0;
    localparam int CTL_WAVE   = 1;
    localparam int CTL_FALL   = 2;
    localparam int CTL_PRESET = 3;
    localparam int CTL_IE_LO  = 4;

    localparam int NUM_SRC   = 4;
    localparam int SRC_A     = 0;
    localparam int SRC_B     = 1;
    localparam int SRC_C     = 2;
    localparam int SRC_D     = 3;
    localparam int CTL_WIDTH = CTL_IE_LO + NUM_SRC;

endpackage

// File: rtl/tmr_cap_qual.sv
module tmr_cap_qual
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic cap_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   active;
    logic                   pol_q;
    cap_state_e             state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl    = sync_q[SYNC_STAGES-1];
    assign active = fall_sel ? ~lvl : lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pol_q   <= fall_sel;
        end
    end

    always_comb begin
        state_d = state_q;
        if (pol_q != fall_sel) begin
            state_d = CAP_WAIT;
        end else begin
            unique case (state_q)
                CAP_WAIT:  if (!active) state_d = CAP_ARMED;
                CAP_ARMED: if (active)  state_d = CAP_FIRE;
                CAP_FIRE:  state_d = active ? CAP_WAIT : CAP_ARMED;
                default:   state_d = CAP_WAIT;
            endcase
        end
    end

    always_comb begin
        cap_evt = 1'b0;
        unique case (state_q)
            CAP_FIRE: cap_evt = 1'b1;
            default:  cap_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_reload_cnt.sv
module tmr_reload_cnt #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             wave_en,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] reload,
    output logic [WIDTH-1:0] count,
    output logic             uf,
    output logic             wave
);
    logic step;

    assign step = run & tick & ~wr_en;
    assign uf   = step & (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (uf) begin
            count <= reload;
        end else if (step) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             wave <= 1'b0;
        else if (uf && wave_en) wave <= ~wave;
    end

endmodule

// File: rtl/tmr_capture_cnt.sv
module tmr_capture_cnt #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cap_evt,
    input  logic             preset_en,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] capt,
    output logic             uf
);
    logic preset;

    assign preset = cap_evt & preset_en & ~wr_en;
    assign uf     = tick & ~wr_en & ~preset & (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '1;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (preset) begin
            count <= '1;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capt <= '0;
        else if (cap_evt) capt <= count;
    end

endmodule

// File: rtl/dual_timer_capture.sv
module dual_timer_capture
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cap_pin,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    output logic              wave_o,
    output logic              irq1_o,
    output logic              irq2_o
);
    logic [CTL_WIDTH-1:0] ctrl_q;
    logic [NUM_SRC-1:0]   pend_q;
    logic [NUM_SRC-1:0]   pend_set;
    logic [NUM_SRC-1:0]   pend_clr;
    logic [NUM_SRC-1:0]   ie;
    logic [NUM_SRC-1:0]   live;
    logic [WIDTH-1:0]     reload_q;
    logic [WIDTH-1:0]     cnt1;
    logic [WIDTH-1:0]     cnt2;
    logic [WIDTH-1:0]     capt;
    logic                 wr_cnt1, wr_cnt2;
    logic                 uf1, uf2, cap_evt;
    logic                 preset_en, wave_en;

    assign wr_cnt1   = reg_we && (reg_addr == ADDR_CNT1);
    assign wr_cnt2   = reg_we && (reg_addr == ADDR_CNT2);
    assign preset_en = ctrl_q[CTL_PRESET];
    assign wave_en   = ctrl_q[CTL_WAVE];
    assign ie        = ctrl_q[CTL_IE_LO +: NUM_SRC];

    tmr_cap_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .fall_sel (ctrl_q[CTL_FALL]),
        .cap_evt  (cap_evt)
    );

    tmr_reload_cnt #(.WIDTH(WIDTH)) u_cnt1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (ctrl_q[CTL_RUN1]),
        .wave_en (wave_en),
        .wr_en   (wr_cnt1),
        .wr_data (reg_wdata),
        .reload  (reload_q),
        .count   (cnt1),
        .uf      (uf1),
        .wave    (wave_o)
    );

    tmr_capture_cnt #(.WIDTH(WIDTH)) u_cnt2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_cnt2),
        .wr_data   (reg_wdata),
        .cap_evt   (cap_evt),
        .preset_en (preset_en),
        .count     (cnt2),
        .capt      (capt),
        .uf        (uf2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) ctrl_q   <= reg_wdata[CTL_WIDTH-1:0];
            if (reg_addr == ADDR_RLD)  reload_q <= reg_wdata;
        end
    end

    always_comb begin
        pend_set        = '0;
        pend_set[SRC_A] = uf1;
        pend_set[SRC_B] = cap_evt;
        pend_set[SRC_C] = 1'b0;
        pend_set[SRC_D] = uf2;
        pend_clr        = (reg_we && reg_addr == ADDR_PEND) ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | pend_set;
    end

    assign live   = pend_q & ie;
    assign irq1_o = |live[SRC_C:SRC_A];
    assign irq2_o = live[SRC_D];

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(WIDTH-CTL_WIDTH){1'b0}}, ctrl_q};
            ADDR_PEND: reg_rdata = {{(WIDTH-NUM_SRC){1'b0}}, pend_q};
            ADDR_RLD:  reg_rdata = reload_q;
            ADDR_CNT1: reg_rdata = cnt1;
            ADDR_CNT2: reg_rdata = cnt2;
            ADDR_CAPT: reg_rdata = capt;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cap_evt,
    input logic             wr_cnt2,
    input logic             preset_en,
    input logic [WIDTH-1:0] cnt2,
    input logic [WIDTH-1:0] capt,
    input logic [3:0]       pend_q,
    input logic             uf1,
    input logic [WIDTH-1:0] cnt1,
    input logic [WIDTH-1:0] reload_q,
    input logic             wave_en,
    input logic             wave_o,
    input logic             irq2_o,
    input logic [7:0]       ctrl_q
);
    assert_cnt2_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cap_evt && !wr_cnt2 && cnt2 != '0) |=> (cnt2 == $past(cnt2) - 1'b1));

    assert_cnt2_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cap_evt && !wr_cnt2 && cnt2 == '0) |=> (cnt2 == '1 && pend_q[3]));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capt == $past(cnt2) && pend_q[1]));

    assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && preset_en && !wr_cnt2) |=> (cnt2 == '1));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uf1 |=> (cnt1 == $past(reload_q) && pend_q[0]));

    assert_wave_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf1 && wave_en) |=> (wave_o != $past(wave_o)));

    assert_wave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !uf1 |=> $stable(wave_o));

    assert_irq2_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq2_o) |-> (pend_q[3] && ctrl_q[7]));

endmodule

bind dual_timer_capture tmr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cap_evt   (cap_evt),
    .wr_cnt2   (wr_cnt2),
    .preset_en (preset_en),
    .cnt2      (cnt2),
    .capt      (capt),
    .pend_q    (pend_q),
    .uf1       (uf1),
    .cnt1      (cnt1),
    .reload_q  (reload_q),
    .wave_en   (wave_en),
    .wave_o    (wave_o),
    .irq2_o    (irq2_o),
    .ctrl_q    (ctrl_q)
);

// File: tb/dual_timer_capture_tb.sv
module dual_timer_capture_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cap_pin = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        wave_o, irq1_o, irq2_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_timer_capture u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cap_pin   (cap_pin),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wave_o    (wave_o),
        .irq1_o    (irq1_o),
        .irq2_o    (irq2_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R10 ctrl", v, 16'h0000);
        rd(3'd1, v); check("R10 pend", v, 16'h0000);
        rd(3'd3, v); check("R10 cnt1", v, 16'h0000);
        rd(3'd4, v); check("R10 cnt2", v, 16'hFFFF);
        rd(3'd5, v); check("R10 capt", v, 16'h0000);
        check("R10 irq/wave", {13'd0, wave_o, irq1_o, irq2_o}, 16'h0000);
    endtask

    task automatic t_cnt2_step();
        logic [15:0] v;
        ticks(5);
        rd(3'd4, v); check("R1 after 5 ticks", v, 16'hFFFA);
        idle(8);
        rd(3'd4, v); check("R1 hold without tick", v, 16'hFFFA);
    endtask

    task automatic t_cnt2_wrap();
        logic [15:0] v;
        wr(3'd1, 16'h000F);
        wr(3'd4, 16'h0002);
        ticks(2);
        rd(3'd1, v); check("R2 no flag before wrap", v, 16'h0000);
        ticks(1);
        rd(3'd4, v); check("R2 wrapped count", v, 16'hFFFF);
        rd(3'd1, v); check("R2 pending D", v, 16'h0008);
        wr(3'd0, 16'h0080);
        check("R9 irq2 with D enabled", {15'd0, irq2_o}, 16'h0001);
        check("R9 irq1 low for D", {15'd0, irq1_o}, 16'h0000);
        wr(3'd0, 16'h0000);
        check("R9 irq2 masked", {15'd0, irq2_o}, 16'h0000);
    endtask

    task automatic t_capture_rise();
        logic [15:0] v;
        wr(3'd1, 16'h000F);
        wr(3'd4, 16'h1234);
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk); cap_pin = 1'b0;
        idle(6);
        rd(3'd5, v); check("R3 captured value", v, 16'h1234);
        rd(3'd1, v); check("R3 pending B", v, 16'h0002);
        rd(3'd4, v); check("R5 no preset keeps count", v, 16'h1234);
    endtask

    task automatic t_capture_fall();
        logic [15:0] v;
        wr(3'd0, 16'h0004);
        wr(3'd1, 16'h000F);
        wr(3'd4, 16'h0BEE);
        idle(4);
        @(negedge clk); cap_pin = 1'b1;
        idle(6);
        rd(3'd5, v); check("R4 rising ignored in falling mode", v, 16'h1234);
        rd(3'd1, v); check("R4 no flag on rising", v, 16'h0000);
        @(negedge clk); cap_pin = 1'b0;
        idle(6);
        rd(3'd5, v); check("R4 falling captured", v, 16'h0BEE);
        rd(3'd1, v); check("R4 pending B on falling", v, 16'h0002);
    endtask

    task automatic t_preset();
        logic [15:0] v;
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h000F);
        idle(4);
        wr(3'd4, 16'h00AA);
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk); cap_pin = 1'b0;
        idle(6);
        rd(3'd5, v); check("R5 latched before preset", v, 16'h00AA);
        rd(3'd4, v); check("R5 count preset", v, 16'hFFFF);
    endtask

    task automatic t_reload();
        logic [15:0] v;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h000F);
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h0001);
        ticks(2);
        rd(3'd3, v); check("R6 stopped counter holds", v, 16'h0001);
        wr(3'd0, 16'h0003);
        ticks(1);
        rd(3'd3, v); check("R6 step to zero", v, 16'h0000);
        check("R7 wave before underflow", {15'd0, wave_o}, 16'h0000);
        ticks(1);
        rd(3'd3, v); check("R6 reloaded", v, 16'h0003);
        rd(3'd1, v); check("R6 pending A", v & 16'h0001, 16'h0001);
        check("R7 wave toggled high", {15'd0, wave_o}, 16'h0001);
        ticks(4);
        check("R7 wave toggled low", {15'd0, wave_o}, 16'h0000);
        wr(3'd0, 16'h0001);
        ticks(4);
        check("R7 wave held when disabled", {15'd0, wave_o}, 16'h0000);
    endtask

    task automatic t_w1c_irq();
        logic [15:0] v;
        wr(3'd1, 16'h000F);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0001);
        ticks(2);
        @(negedge clk); cap_pin = 1'b1;
        @(negedge clk); cap_pin = 1'b0;
        idle(6);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h0001);
        ticks(1);
        wr(3'd0, 16'h0000);
        rd(3'd1, v); check("R8 A B D pending", v, 16'h000B);
        wr(3'd0, 16'h0010);
        check("R9 irq1 from A", {15'd0, irq1_o}, 16'h0001);
        wr(3'd1, 16'h0001);
        rd(3'd1, v); check("R8 only A cleared", v, 16'h000A);
        check("R9 irq1 low after clear", {15'd0, irq1_o}, 16'h0000);
        wr(3'd0, 16'h0020);
        check("R9 irq1 from B", {15'd0, irq1_o}, 16'h0001);
        check("R9 irq2 low D masked", {15'd0, irq2_o}, 16'h0000);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); check("R8 zero write no effect", v, 16'h000A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cnt2_step();
        t_cnt2_wrap();
        t_capture_rise();
        t_capture_fall();
        t_preset();
        t_reload();
        t_w1c_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule